// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses, for each of six counters, which signal drives its clock and which drives its gate. The six counters form two groups of three. Software programs the routing with single-byte writes. A strobe selects one of two registers: clock routing or gate routing. Each byte names its own target counter and carries a 5-bit source code. The block stores one source code per counter in each register. It drives one combinational multiplexer per counter and per function. Each multiplexer picks from up to 32 candidate taps.

The byte layout has fixed positions. Bit 5 is the group select and bits 4:3 are the channel inside the group. The source code is split across two fields: bits 2:0 hold the low three bits of the code and bits 7:6 hold the high two bits. A mode input widens the legal code range from 0..7 to 0..31. Code 0 has a fixed meaning. For a clock it selects the counter's own dedicated external clock, and for a gate it selects constant high. Each other code selects an entry of a tap vector. Taps that the build does not connect read as low. The counters and the reference clock dividers sit outside this block and are seen only as tap inputs.

Top module: `cntsrc_router`

## Requirements
- R1: After reset every stored clock code and gate code is 0, so each counter clock follows its dedicated external clock and each gate is high.
- R2: A write addresses counter index group*3 + channel, with group taken from byte bit 5 and channel from byte bits 4:3.
- R3: A write changes only the addressed counter's stored code. All other counters keep their routing.
- R4: With `wr_sel` = 0 a write goes to the clock routing register, and with `wr_sel` = 1 it goes to the gate routing register. A write to one register leaves the other unchanged.
- R5: A byte whose channel field (bits 4:3) equals 3 is ignored by both registers.
- R6: With `enh_mode` low at the write, the stored code is byte bits 2:0 and byte bits 7:6 are ignored. This gives codes 0..7.
- R7: With `enh_mode` high at the write, the stored code is {bits 7:6, bits 2:0}, which gives 0..31. A later change of `enh_mode` does not alter codes already stored.
- R8: Clock code 0 routes `ext_clk[i]` to `ctr_clk[i]`, and gate code 0 drives `ctr_gate[i]` high.
- R9: A nonzero code s whose bit is set in the connection mask routes `clk_taps[s]` (clock) or `gate_taps[s]` (gate) to the counter output.
- R10: A nonzero code whose bit is clear in the connection mask drives the output low, whatever the tap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 1 | 0 = clock routing register, 1 = gate routing register |
| wr_data | input | 8 | Self-addressed routing byte |
| enh_mode | input | 1 | Widens the legal code range to 5 bits when high |
| ext_clk | input | NUM_CTR | Dedicated external clock per counter |
| clk_taps | input | 32 | Candidate clock sources, indexed by code |
| gate_taps | input | 32 | Candidate gate sources, indexed by code |
| ctr_clk | output | NUM_CTR | Routed clock per counter |
| ctr_gate | output | NUM_CTR | Routed gate per counter |

## Verification
The bench uses the default build: three channels per group, a clock connection mask of 0x0000F83F and a gate connection mask of 0x00FF00FF. With the clock mask, codes 1..5 and 11..15 are live, while codes 6 and 20 are holes. That makes it possible to show an unconnected code reading low while every tap is high. The gate mask leaves code 9 dead and code 16 live, so the same split is tested on the gate side with enhanced codes. Tap vectors with a single high bit make every output show exactly which code it holds.

// File: rtl/cntsrc_pkg.sv
package cntsrc_pkg;
  localparam int BYTE_W   = 8;
  localparam int SRC_W    = 5;
  localparam int NUM_SRC  = 1 << SRC_W;
  localparam int LO_W     = 3;
  localparam int GRP_BIT  = 5;
  localparam int CH_LSB   = 3;
  localparam int CH_W     = 2;
  localparam int HI_LSB   = 6;
  localparam int NUM_GRP  = 2;

  typedef struct packed {
    logic            grp;
    logic [CH_W-1:0] chan;
    logic [SRC_W-1:0] code;
  } route_cmd_t;

  function automatic route_cmd_t unpack_byte(input logic [BYTE_W-1:0] b,
                                             input logic enh);
    route_cmd_t c;
    c.grp  = b[GRP_BIT];
    c.chan = b[CH_LSB +: CH_W];
    c.code = {(enh ? b[HI_LSB +: SRC_W-LO_W] : {(SRC_W-LO_W){1'b0}}), b[LO_W-1:0]};
    return c;
  endfunction
endpackage

// File: rtl/cntsrc_decode.sv
module cntsrc_decode
  import cntsrc_pkg::*;
#(
  parameter int CH_PER_GROUP = 3,
  localparam int NUM_CTR = NUM_GRP * CH_PER_GROUP,
  localparam int IDX_W   = $clog2(NUM_CTR)
) (
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              enh_mode,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [SRC_W-1:0]  tgt_code,
  output logic              tgt_hit
);
  route_cmd_t cmd;

  always_comb begin
    cmd      = unpack_byte(wr_data, enh_mode);
    tgt_code = cmd.code;
    tgt_hit  = (int'(cmd.chan) < CH_PER_GROUP);
    tgt_idx  = IDX_W'(int'(cmd.grp) * CH_PER_GROUP + int'(cmd.chan));
  end
endmodule

// File: rtl/cntsrc_bank.sv
module cntsrc_bank
  import cntsrc_pkg::*;
#(
  parameter int NUM_CTR = 6,
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [IDX_W-1:0]         ld_idx,
  input  logic [SRC_W-1:0]         ld_code,
  output logic [NUM_CTR*SRC_W-1:0] codes_q
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    logic             slot_ld;
    logic [SRC_W-1:0] slot_d;

    always_comb begin
      slot_ld = ld_en && (ld_idx == IDX_W'(i));
      slot_d  = slot_ld ? ld_code : codes_q[i*SRC_W +: SRC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) codes_q[i*SRC_W +: SRC_W] <= '0;
      else        codes_q[i*SRC_W +: SRC_W] <= slot_d;
    end
  end
endmodule

// File: rtl/cntsrc_mux.sv
module cntsrc_mux
  import cntsrc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] TAP_MASK = '1
) (
  input  logic [SRC_W-1:0]   code,
  input  logic               zero_src,
  input  logic [NUM_SRC-1:0] taps,
  output logic               sel_out
);
  logic [NUM_SRC-1:0] live;

  assign live[0] = zero_src;
  for (genvar s = 1; s < NUM_SRC; s++) begin : g_tap
    if (TAP_MASK[s]) begin : g_on
      assign live[s] = taps[s];
    end else begin : g_off
      assign live[s] = 1'b0;
    end
  end

  assign sel_out = live[code];
endmodule

// File: rtl/cntsrc_router.sv
module cntsrc_router
  import cntsrc_pkg::*;
#(
  parameter int CH_PER_GROUP = 3,
  parameter logic [NUM_SRC-1:0] CLK_TAP_MASK  = 32'h0000_F83F,
  parameter logic [NUM_SRC-1:0] GATE_TAP_MASK = 32'h00FF_00FF,
  localparam int NUM_CTR = NUM_GRP * CH_PER_GROUP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               enh_mode,
  input  logic [NUM_CTR-1:0] ext_clk,
  input  logic [NUM_SRC-1:0] clk_taps,
  input  logic [NUM_SRC-1:0] gate_taps,
  output logic [NUM_CTR-1:0] ctr_clk,
  output logic [NUM_CTR-1:0] ctr_gate
);
  localparam int IDX_W = $clog2(NUM_CTR);

  logic [IDX_W-1:0]         tgt_idx;
  logic [SRC_W-1:0]         tgt_code;
  logic                     tgt_hit;
  logic                     clk_ld, gate_ld;
  logic [NUM_CTR*SRC_W-1:0] clk_codes_q, gate_codes_q;

  cntsrc_decode #(.CH_PER_GROUP(CH_PER_GROUP)) u_dec (
    .wr_data  (wr_data),
    .enh_mode (enh_mode),
    .tgt_idx  (tgt_idx),
    .tgt_code (tgt_code),
    .tgt_hit  (tgt_hit)
  );

  assign clk_ld  = wr_en && tgt_hit && !wr_sel;
  assign gate_ld = wr_en && tgt_hit &&  wr_sel;

  cntsrc_bank #(.NUM_CTR(NUM_CTR)) u_clk_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (clk_ld),
    .ld_idx  (tgt_idx),
    .ld_code (tgt_code),
    .codes_q (clk_codes_q)
  );

  cntsrc_bank #(.NUM_CTR(NUM_CTR)) u_gate_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (gate_ld),
    .ld_idx  (tgt_idx),
    .ld_code (tgt_code),
    .codes_q (gate_codes_q)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    cntsrc_mux #(.TAP_MASK(CLK_TAP_MASK)) u_clk_mux (
      .code     (clk_codes_q[i*SRC_W +: SRC_W]),
      .zero_src (ext_clk[i]),
      .taps     (clk_taps),
      .sel_out  (ctr_clk[i])
    );
    cntsrc_mux #(.TAP_MASK(GATE_TAP_MASK)) u_gate_mux (
      .code     (gate_codes_q[i*SRC_W +: SRC_W]),
      .zero_src (1'b1),
      .taps     (gate_taps),
      .sel_out  (ctr_gate[i])
    );
  end
endmodule

// File: rtl/cntsrc_router_chk.sv
module cntsrc_router_chk
  import cntsrc_pkg::*;
#(
  parameter int NUM_CTR = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     wr_sel,
  input logic [BYTE_W-1:0]        wr_data,
  input logic [NUM_CTR-1:0]       ext_clk,
  input logic [NUM_CTR-1:0]       ctr_clk,
  input logic [NUM_CTR-1:0]       ctr_gate,
  input logic [NUM_CTR*SRC_W-1:0] clk_codes_q,
  input logic [NUM_CTR*SRC_W-1:0] gate_codes_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (clk_codes_q == '0 && gate_codes_q == '0);
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clk_codes_q) && $stable(gate_codes_q));

  p_gate_wr_keeps_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> $stable(clk_codes_q));

  p_clk_wr_keeps_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> $stable(gate_codes_q));

  p_chan3_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[CH_LSB +: CH_W] == 2'b11 |=> $stable(clk_codes_q) && $stable(gate_codes_q));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    p_clk_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_codes_q[i*SRC_W +: SRC_W] == '0 |-> ctr_clk[i] == ext_clk[i]);
    p_gate_zero_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_codes_q[i*SRC_W +: SRC_W] == '0 |-> ctr_gate[i]);
  end
endmodule

bind cntsrc_router cntsrc_router_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .ext_clk      (ext_clk),
  .ctr_clk      (ctr_clk),
  .ctr_gate     (ctr_gate),
  .clk_codes_q  (clk_codes_q),
  .gate_codes_q (gate_codes_q)
);

// File: tb/test_cntsrc_router.sv
module test_cntsrc_router;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_sel, enh_mode;
  logic [7:0]    wr_data;
  logic [NC-1:0] ext_clk;
  logic [31:0]   clk_taps, gate_taps;
  logic [NC-1:0] ctr_clk, ctr_gate;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cntsrc_router i_cntsrc_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .enh_mode(enh_mode), .ext_clk(ext_clk),
    .clk_taps(clk_taps), .gate_taps(gate_taps),
    .ctr_clk(ctr_clk), .ctr_gate(ctr_gate)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Byte: {code[4:3], group, chan[1:0], code[2:0]}
  task automatic wr(input logic sel, input int ctr, input logic [1:0] ch_ovr,
                    input bit use_ovr, input logic [4:0] code, input logic enh);
    logic [1:0] ch;
    logic       grp;
    grp = (ctr >= 3);
    ch  = use_ovr ? ch_ovr : 2'(ctr % 3);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_sel   = sel;
    enh_mode = enh;
    wr_data  = {code[4:3], grp, ch, code[2:0]};
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic settle(); #1; endtask

  task automatic t_reset();
    ext_clk = 6'b101101; clk_taps = '1; gate_taps = '0; settle();
    chk("R1 clk after reset", 32'(ctr_clk), 32'h2D);
    chk("R1 gate after reset", 32'(ctr_gate), 32'h3F);
    ext_clk = 6'b010010; settle();
    chk("R8 clk follows ext", 32'(ctr_clk), 32'h12);
  endtask

  task automatic t_address();
    ext_clk = '0; clk_taps = 32'h2;
    for (int i = 0; i < NC; i++) begin
      wr(1'b0, i, 2'b00, 1'b0, 5'd1, 1'b0);
      chk("R2 R3 R9 counter addressing", 32'(ctr_clk), (32'h1 << (i+1)) - 1);
    end
  endtask

  task automatic t_separate();
    gate_taps = '0;
    wr(1'b1, 4, 2'b00, 1'b0, 5'd2, 1'b0);
    chk("R4 gate write target", 32'(ctr_gate), 32'h2F);
    chk("R4 clock untouched by gate write", 32'(ctr_clk), 32'h3F);
    clk_taps = '0; settle();
    chk("R4 clock codes still 1", 32'(ctr_clk), 32'h00);
    ext_clk = 6'h3F;
    wr(1'b0, 4, 2'b00, 1'b0, 5'd0, 1'b0);
    chk("R4 clock write back to 0", 32'(ctr_clk), 32'h10);
    chk("R4 gate untouched by clock write", 32'(ctr_gate), 32'h2F);
  endtask

  task automatic t_chan3();
    ext_clk = '0; clk_taps = 32'h2;
    wr(1'b0, 0, 2'b11, 1'b1, 5'd3, 1'b0);
    wr(1'b0, 3, 2'b11, 1'b1, 5'd2, 1'b0);
    wr(1'b1, 3, 2'b11, 1'b1, 5'd0, 1'b0);
    chk("R5 channel 3 ignored clk", 32'(ctr_clk), 32'h2F);
    chk("R5 channel 3 ignored gate", 32'(ctr_gate), 32'h2F);
  endtask

  task automatic t_basic();
    wr(1'b0, 0, 2'b00, 1'b0, 5'b11011, 1'b0);
    clk_taps = 32'h0000_0008; settle();
    chk("R6 basic uses low bits", 32'(ctr_clk[0]), 32'h1);
    clk_taps = 32'h0800_0000; settle();
    chk("R6 basic high bits ignored", 32'(ctr_clk[0]), 32'h0);
  endtask

  task automatic t_enh();
    wr(1'b0, 2, 2'b00, 1'b0, 5'd11, 1'b1);
    clk_taps = 32'h1 << 11; settle();
    chk("R7 enhanced code 11 high", 32'(ctr_clk[2]), 32'h1);
    clk_taps = 32'h1 << 3; settle();
    chk("R7 enhanced code 11 not 3", 32'(ctr_clk[2]), 32'h0);
    wr(1'b0, 5, 2'b00, 1'b0, 5'd15, 1'b1);
    clk_taps = 32'h1 << 15; settle();
    chk("R7 enhanced code 15", 32'(ctr_clk[5]), 32'h1);
    enh_mode = 1'b0;
    clk_taps = 32'h1 << 11; settle();
    chk("R7 stored code kept after mode off", 32'(ctr_clk[2]), 32'h1);
  endtask

  task automatic t_unconn();
    clk_taps = '1; gate_taps = '1;
    wr(1'b0, 1, 2'b00, 1'b0, 5'd20, 1'b1);
    chk("R10 clock code 20 unconnected", 32'(ctr_clk[1]), 32'h0);
    wr(1'b0, 1, 2'b00, 1'b0, 5'd6, 1'b1);
    chk("R10 clock code 6 unconnected", 32'(ctr_clk[1]), 32'h0);
    wr(1'b1, 0, 2'b00, 1'b0, 5'd9, 1'b1);
    chk("R10 gate code 9 unconnected", 32'(ctr_gate[0]), 32'h0);
    wr(1'b1, 0, 2'b00, 1'b0, 5'd16, 1'b1);
    chk("R9 gate code 16 connected", 32'(ctr_gate[0]), 32'h1);
    gate_taps = '0;
    wr(1'b1, 4, 2'b00, 1'b0, 5'd0, 1'b0);
    chk("R8 gate code 0 high", 32'(ctr_gate[4]), 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; enh_mode = 1'b0; wr_data = '0;
    ext_clk = '0; clk_taps = '0; gate_taps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_address();
    t_separate();
    t_chan3();
    t_basic();
    t_enh();
    t_unconn();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule